// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block sits next to a UART transmitter. It does two jobs. First, it decides what value the shared RTS output pin carries. Second, it conditions the infrared receive input before that input reaches the receiver.

The RTS pin has two uses:
- With automatic direction control off, the pin carries flow-control information: either the software-driven RTS level or the automatic flow-control level.
- With automatic direction control on, the pin becomes the transmit/receive steering line for an RS-485 transceiver. A polarity bit selects which level means "transmit".

The block keeps one piece of state, a line-busy flag:
- The flag rises once the transmit queue or the shift register holds data.
- It falls only when the transmitter reports that the last stop bit has left the line and both storage stages are empty.

The same flag drives echo suppression on the infrared path. The raw infrared input is first passed through a synchronizer. It is then optionally inverted, so that the receiver always sees an idle-low signal. When infrared mode and infrared half-duplex are both enabled and the line is busy, the receiver input is forced to its idle level. This prevents the transmitter's own reflected light from being decoded as a start bit.

Top module: `hdx_line_dir`

## Requirements
- R1: With `cfg_dir_en`=0 and `flow_auto_en`=0, `rts_pin` equals `rts_manual` in the same cycle.
- R2: With `cfg_dir_en`=0 and `flow_auto_en`=1, `rts_pin` equals `rts_flow` in the same cycle, and `rts_manual` has no effect on it.
- R3: With `cfg_dir_en`=1, `rts_pin` is unaffected by `rts_manual`, `rts_flow` and `flow_auto_en`.
- R4: With `cfg_dir_en`=1, `rts_pin` is 1 while busy and 0 while idle when `cfg_dir_inv`=0. When `cfg_dir_inv`=1 it is 0 while busy and 1 while idle. This follows `cfg_dir_inv` in the same cycle.
- R5: The line becomes busy at the first rising clock edge at which `txq_empty`=0 or `tsr_empty`=0 is sampled.
- R6: A busy line stays busy until an edge at which `stop_done`=1 with `txq_empty`=1 and `tsr_empty`=1 is sampled. At that edge it becomes idle. A `stop_done` pulse while either stage holds data leaves it busy.
- R7: After reset the line is idle: with `cfg_dir_en`=1, `rts_pin` equals `cfg_dir_inv`.
- R8: `ir_rx` equals `ir_raw` XOR `cfg_ir_inv`, where `ir_raw` is the value sampled SYNC_STAGES rising edges earlier. `cfg_ir_inv` takes effect in the same cycle.
- R9: While `cfg_ir_en`=1, `cfg_ir_hdx`=1 and the line is busy, `ir_rx` is held at 0, its idle level.
- R10: With `cfg_ir_hdx`=0 or `cfg_ir_en`=0, `ir_rx` keeps following the infrared input while the line is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txq_empty | input | 1 | Transmit queue holds no data |
| tsr_empty | input | 1 | Transmit shift register holds no data |
| stop_done | input | 1 | Last stop bit has fully left the line |
| rts_manual | input | 1 | Software-driven RTS level |
| rts_flow | input | 1 | Automatic flow-control RTS level |
| flow_auto_en | input | 1 | Select `rts_flow` over `rts_manual` |
| ir_raw | input | 1 | Raw infrared receive input |
| cfg_ir_en | input | 1 | Infrared mode enable |
| cfg_ir_hdx | input | 1 | Infrared half-duplex (echo blocking) enable |
| cfg_ir_inv | input | 1 | Infrared input idles high and pulses low |
| cfg_dir_en | input | 1 | Automatic RS-485 direction control enable |
| cfg_dir_inv | input | 1 | Invert direction polarity |
| rts_pin | output | 1 | RTS output pin value |
| ir_rx | output | 1 | Conditioned infrared signal to the receiver (idles at 0) |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default of 2. This makes the synchronizer latency distinct from both the one-cycle busy-flag latency and from a default-sized chain. A wrong tap point or a missing stage therefore shows up as a value arriving one edge early or late. The busy flag and the blocking window are observed through `rts_pin` and `ir_rx`. This covers the sequences where `stop_done` arrives while data is still present and where the polarity bit flips mid-transmission.

// File: rtl/hdx_line_dir.sv
module hdx_line_dir #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txq_empty,
  input  logic tsr_empty,
  input  logic stop_done,
  input  logic rts_manual,
  input  logic rts_flow,
  input  logic flow_auto_en,
  input  logic ir_raw,
  input  logic cfg_ir_en,
  input  logic cfg_ir_hdx,
  input  logic cfg_ir_inv,
  input  logic cfg_dir_en,
  input  logic cfg_dir_inv,
  output logic rts_pin,
  output logic ir_rx
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic                 data_held;
  logic                 busy_q;
  logic [SYNC_MSB:0]    ir_sync;
  logic                 ir_level;
  logic                 ir_block;
  logic                 flow_rts;

  assign data_held = !txq_empty || !tsr_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)
      busy_q <= 1'b0;
    else if (data_held)
      busy_q <= 1'b1;
    else if (stop_done)
      busy_q <= 1'b0;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rst_n) ir_sync <= '0;
        else        ir_sync <= ir_raw;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rst_n) ir_sync <= '0;
        else        ir_sync <= {ir_sync[SYNC_MSB-1:0], ir_raw};
      end
    end
  endgenerate

  assign flow_rts = flow_auto_en ? rts_flow : rts_manual;
  assign rts_pin  = cfg_dir_en ? (busy_q ^ cfg_dir_inv) : flow_rts;

  assign ir_level = ir_sync[SYNC_MSB] ^ cfg_ir_inv;
  assign ir_block = cfg_ir_en & cfg_ir_hdx & busy_q;
  assign ir_rx    = ir_level & ~ir_block;
endmodule

// File: rtl/hdx_line_dir_chk.sv
module hdx_line_dir_chk (
  input logic clk,
  input logic rst_n,
  input logic txq_empty,
  input logic tsr_empty,
  input logic stop_done,
  input logic rts_manual,
  input logic rts_flow,
  input logic flow_auto_en,
  input logic cfg_ir_en,
  input logic cfg_ir_hdx,
  input logic cfg_dir_en,
  input logic cfg_dir_inv,
  input logic busy_q,
  input logic rts_pin,
  input logic ir_rx
);
  p_manual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dir_en && !flow_auto_en && $stable(cfg_dir_en) && $stable(flow_auto_en)
     && $stable(rts_manual)) |-> $stable(rts_pin));

  p_flow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dir_en && flow_auto_en && $stable(cfg_dir_en) && $stable(flow_auto_en)
     && $stable(rts_flow)) |-> $stable(rts_pin));

  p_dir_ignores_flow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir_en && $stable(cfg_dir_en) && $stable(cfg_dir_inv) && $stable(busy_q))
     |-> $stable(rts_pin));

  p_enter_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!txq_empty || !tsr_empty) |=> busy_q);

  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stop_done) |=> busy_q);

  p_leave_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && stop_done && txq_empty && tsr_empty) |=> !busy_q);

  p_stay_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && txq_empty && tsr_empty) |=> !busy_q);

  p_echo_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ir_en && cfg_ir_hdx && busy_q) |-> !ir_rx);
endmodule

bind hdx_line_dir hdx_line_dir_chk i_hdx_line_dir_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .txq_empty    (txq_empty),
  .tsr_empty    (tsr_empty),
  .stop_done    (stop_done),
  .rts_manual   (rts_manual),
  .rts_flow     (rts_flow),
  .flow_auto_en (flow_auto_en),
  .cfg_ir_en    (cfg_ir_en),
  .cfg_ir_hdx   (cfg_ir_hdx),
  .cfg_dir_en   (cfg_dir_en),
  .cfg_dir_inv  (cfg_dir_inv),
  .busy_q       (busy_q),
  .rts_pin      (rts_pin),
  .ir_rx        (ir_rx)
);

// File: tb/test_hdx_line_dir.sv
`timescale 1ns/1ps
module test_hdx_line_dir;
  localparam int SYNC_STAGES = 3;
  localparam int NVEC = 10;
  // {dir_en, dir_inv, flow_auto, manual, flow, expected rts_pin}; line idle
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000_00_0, 6'b000_10_1, 6'b000_01_0, 6'b001_01_1, 6'b001_10_0,
    6'b001_11_1, 6'b100_11_0, 6'b101_11_0, 6'b110_00_1, 6'b111_10_1
  };

  logic clk = 0, rst_n = 0;
  logic txq_empty = 1, tsr_empty = 1, stop_done = 0;
  logic rts_manual = 0, rts_flow = 0, flow_auto_en = 0, ir_raw = 0;
  logic cfg_ir_en = 0, cfg_ir_hdx = 0, cfg_ir_inv = 0, cfg_dir_en = 0, cfg_dir_inv = 0;
  logic rts_pin, ir_rx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hdx_line_dir #(.SYNC_STAGES(SYNC_STAGES)) i_hdx_line_dir (.*);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    cfg_dir_en = 1; cfg_dir_inv = 1; #1;
    check("R7 idle after reset, inverted", rts_pin, 1'b1);
    cfg_dir_inv = 0; #1;
    check("R7 idle after reset", rts_pin, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {cfg_dir_en, cfg_dir_inv, flow_auto_en, rts_manual, rts_flow} = VEC[i][5:1];
      #1;
      check(VEC[i][5] ? "R3/R4 vector" : (VEC[i][3] ? "R2 vector" : "R1 vector"),
            rts_pin, VEC[i][0]);
    end

    @(negedge clk);
    cfg_dir_en = 1; cfg_dir_inv = 0; flow_auto_en = 0; rts_manual = 0; rts_flow = 0;
    txq_empty = 0; #1;
    check("R5 not busy before edge", rts_pin, 1'b0);
    tick();
    check("R5 busy after edge", rts_pin, 1'b1);
    rts_manual = 1; rts_flow = 1; flow_auto_en = 1; #1;
    check("R3 flow inputs ignored", rts_pin, 1'b1);
    txq_empty = 1; tsr_empty = 0; tick();
    check("R6 busy while shift reg full", rts_pin, 1'b1);
    stop_done = 1; tick();
    check("R6 stop_done with data held", rts_pin, 1'b1);
    tsr_empty = 1; stop_done = 0; tick(); tick();
    check("R6 busy until stop_done", rts_pin, 1'b1);
    cfg_dir_inv = 1; #1;
    check("R4 inverted while busy", rts_pin, 1'b0);
    cfg_dir_inv = 0;
    stop_done = 1; tick();
    stop_done = 0;
    check("R6 idle after stop_done", rts_pin, 1'b0);
    tick();
    check("R6 stays idle", rts_pin, 1'b0);
    flow_auto_en = 0; rts_manual = 0; rts_flow = 0;

    cfg_ir_en = 1; cfg_ir_hdx = 1; cfg_ir_inv = 0;
    ir_raw = 1; tick(); tick();
    check("R8 sync latency not yet", ir_rx, 1'b0);
    tick();
    check("R8 sync latency reached", ir_rx, 1'b1);
    cfg_ir_inv = 1; #1;
    check("R8 invert", ir_rx, 1'b0);
    ir_raw = 0; repeat (SYNC_STAGES) tick();
    check("R8 inverted active-low pulse", ir_rx, 1'b1);
    tsr_empty = 0; tick();
    check("R9 blocked while busy", ir_rx, 1'b0);
    cfg_ir_hdx = 0; #1;
    check("R10 half-duplex off passes", ir_rx, 1'b1);
    cfg_ir_hdx = 1; cfg_ir_en = 0; #1;
    check("R10 ir mode off passes", ir_rx, 1'b1);
    cfg_ir_en = 1; #1;
    check("R9 blocked again", ir_rx, 1'b0);
    tsr_empty = 1; stop_done = 1; tick();
    stop_done = 0;
    check("R9 released after idle", ir_rx, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule